// File: doc/BRIEF.md
# Multi-Channel Conversion Sequencer

This block drives an external successive-approximation converter through a request/acknowledge handshake. Software programs it over a simple synchronous register bus. It can run in two modes. In single-channel mode it converts one addressed input. In scan mode it walks a bitmap of inputs in ascending index order. Either mode can run once or repeat without end. Each result lands in a per-channel data register that carries a fresh-data flag. A sticky end-of-conversion event, gated by an enable, drives the interrupt line.

The block also produces a converter clock enable. This is a single-cycle strobe taken from the bus clock through a 6-bit prescaler that divides by the programmed value plus one. The converter holds `conv_ack` high for one cycle, and the result sits on `conv_data` in that cycle.

Register map, on a 16-bit data bus:
- Address 0, control: bit0 enable, bit1 scan mode, bit2 repeat, bit3 interrupt enable, bits[4+:CH_W] channel address. Bit 8 (start) and bit 9 (stop) act only when written as 1 and always read as 0.
- Address 1, status: bit0 end-of-conversion, bit1 busy.
- Address 2: scan bitmap.
- Address 3: divider value in bits[5:0].
- Address 16+k: channel k data, with bit15 the fresh-data flag and bits[9:0] the result.

Top module: `convseq_top`

## Requirements
- R1: After reset, every register reads 0 and both `conv_req` and `irq` are low. A read returns its data on `bus_rdata` one clock after the read cycle.
- R2: In single-channel mode (bit1=0, bit2=0), start converts the addressed channel exactly once and then returns to idle (busy=0).
- R3: In single-channel mode with repeat (bit2=1), the addressed channel is converted again and again until stopped.
- R4: In one-shot scan mode (bit1=1), each channel whose bitmap bit is set is converted once, lowest index first, and then the block returns to idle. A start with an empty bitmap does nothing.
- R5: In repeating scan mode, the sweep wraps from the highest selected channel back to the lowest.
- R6: Writing the stop bit drops `conv_req` within two clocks and idles the sequencer. No further conversion starts.
- R7: A start is ignored while enable (bit0) is clear. Clearing enable idles a running sequencer.
- R8: The end-of-conversion flag (status bit0) is set after each single-channel result, or after the last channel of a scan sweep. Writing 1 to it clears it; writing 0 leaves it unchanged.
- R9: `irq` is high exactly when the end-of-conversion flag and the interrupt enable (control bit3) are both set.
- R10: A result sets the channel's fresh-data flag (bit15) and stores the result in bits[9:0]. Reading the channel register clears the flag and keeps the result.
- R11: `conv_tick` pulses once every divider+1 clocks while enabled and never while disabled. The divider holds 6 bits, so writing 0xFFFF reads back 0x3F.
- R12: `conv_req` stays high with a stable `conv_ch` until `conv_ack`. It drops in the clock after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (5) | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid one clock after the read |
| conv_req | output | 1 | Conversion request to the converter |
| conv_ch | output | CH_W (3) | Channel to convert |
| conv_ack | input | 1 | One-cycle conversion done pulse |
| conv_data | input | RES_W (10) | Conversion result, valid with `conv_ack` |
| conv_tick | output | 1 | Prescaled converter clock enable |
| irq | output | 1 | End-of-conversion interrupt |

## Verification
The embedded properties assume three things about the converter. It acknowledges only while a request is pending. Each acknowledge lasts exactly one clock. It never acknowledges a stale request. The bench responder honours all three: it counts a fixed latency while `conv_req` is high, raises `conv_ack` for one cycle, and then waits for a fresh request. The properties also assume bus accesses use in-range channel addresses. The bench drives every access as a single clean cycle and applies stop or disable only at points where the stop-wins rule decides the outcome.

// File: rtl/convseq_pkg.sv
package convseq_pkg;

    localparam int BUS_W      = 16;
    localparam int ADR_CTRL   = 0;
    localparam int ADR_STAT   = 1;
    localparam int ADR_SCAN   = 2;
    localparam int ADR_DIV    = 3;
    localparam int ADR_CHBASE = 16;

    localparam int CB_EN    = 0;
    localparam int CB_MODE  = 1;
    localparam int CB_RPT   = 2;
    localparam int CB_IEN   = 3;
    localparam int CB_ADDR  = 4;
    localparam int CB_START = 8;
    localparam int CB_STOP  = 9;

    localparam int SB_EOC  = 0;
    localparam int SB_BUSY = 1;

    localparam int NEW_BIT = 15;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_REQ  = 2'd1,
        SQ_GAP  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic en;
        logic scan_mode;
        logic repeat_on;
        logic irq_en;
    } ctrl_flags_t;

endpackage

// File: rtl/convseq_prescaler.sv
module convseq_prescaler #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = en && (cnt_q >= div_val);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R11: after a strobe, the next one comes only when the divider is zero
    p_tick_spacing_r11: assert property (@(posedge clk) disable iff (rst)
        tick |=> (!tick || div_val == '0));

    // R11: no strobe while disabled
    p_tick_gated_r11: assert property (@(posedge clk) disable iff (rst)
        !en |-> !tick);

endmodule

// File: rtl/convseq_regs.sv
module convseq_regs
    import convseq_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DIV_W  = 6,
    parameter int ADDR_W = 5,
    parameter int CH_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output ctrl_flags_t       flags,
    output logic [CH_W-1:0]   ch_addr,
    output logic [NUM_CH-1:0] scan_map,
    output logic [DIV_W-1:0]  div_val,
    output logic              start_p,
    output logic              stop_p,
    input  logic              eoc_set,
    input  logic              busy,
    output logic              irq,
    output logic              ch_rd_en,
    output logic [CH_W-1:0]   ch_rd_idx,
    input  logic [BUS_W-1:0]  ch_rd_word
);

    logic              hit_ctrl, hit_stat, hit_scan, hit_div, hit_ch;
    logic              wr_ctrl, wr_stat, wr_scan, wr_div, rd_any;
    logic [ADDR_W-1:0] ch_off;
    logic [BUS_W-1:0]  rd_word;
    logic [BUS_W-1:0]  rdata_q;
    logic              eoc_q;
    logic              unused_wbits;

    assign unused_wbits = ^bus_wdata;

    assign hit_ctrl = (bus_addr == ADDR_W'(ADR_CTRL));
    assign hit_stat = (bus_addr == ADDR_W'(ADR_STAT));
    assign hit_scan = (bus_addr == ADDR_W'(ADR_SCAN));
    assign hit_div  = (bus_addr == ADDR_W'(ADR_DIV));
    assign ch_off   = bus_addr - ADDR_W'(ADR_CHBASE);
    assign hit_ch   = (bus_addr >= ADDR_W'(ADR_CHBASE)) && (int'(ch_off) < NUM_CH);

    assign wr_ctrl = bus_sel && bus_wr && hit_ctrl;
    assign wr_stat = bus_sel && bus_wr && hit_stat;
    assign wr_scan = bus_sel && bus_wr && hit_scan;
    assign wr_div  = bus_sel && bus_wr && hit_div;
    assign rd_any  = bus_sel && !bus_wr;

    assign ch_rd_en  = rd_any && hit_ch;
    assign ch_rd_idx = CH_W'(ch_off);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags    <= '0;
            ch_addr  <= '0;
            scan_map <= '0;
            div_val  <= '0;
            start_p  <= 1'b0;
            stop_p   <= 1'b0;
        end else begin
            start_p <= wr_ctrl && bus_wdata[CB_START];
            stop_p  <= wr_ctrl && bus_wdata[CB_STOP];
            if (wr_ctrl) begin
                flags.en        <= bus_wdata[CB_EN];
                flags.scan_mode <= bus_wdata[CB_MODE];
                flags.repeat_on <= bus_wdata[CB_RPT];
                flags.irq_en    <= bus_wdata[CB_IEN];
                ch_addr         <= bus_wdata[CB_ADDR +: CH_W];
            end
            if (wr_scan) scan_map <= bus_wdata[NUM_CH-1:0];
            if (wr_div)  div_val  <= bus_wdata[DIV_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            eoc_q <= 1'b0;
        end else if (eoc_set) begin
            eoc_q <= 1'b1;
        end else if (wr_stat && bus_wdata[SB_EOC]) begin
            eoc_q <= 1'b0;
        end
    end

    assign irq = eoc_q && flags.irq_en;

    always_comb begin
        rd_word = '0;
        if (hit_ctrl) begin
            rd_word[CB_EN]            = flags.en;
            rd_word[CB_MODE]          = flags.scan_mode;
            rd_word[CB_RPT]           = flags.repeat_on;
            rd_word[CB_IEN]           = flags.irq_en;
            rd_word[CB_ADDR +: CH_W]  = ch_addr;
        end else if (hit_stat) begin
            rd_word[SB_EOC]  = eoc_q;
            rd_word[SB_BUSY] = busy;
        end else if (hit_scan) begin
            rd_word[NUM_CH-1:0] = scan_map;
        end else if (hit_div) begin
            rd_word[DIV_W-1:0] = div_val;
        end else if (hit_ch) begin
            rd_word = ch_rd_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd_any) begin
            rdata_q <= rd_word;
        end
    end

    assign bus_rdata = rdata_q;

    // R8: a write of 1 clears the flag unless a completion lands in the same cycle
    p_eoc_w1c_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && bus_wdata[SB_EOC] && !eoc_set) |=> !eoc_q);

    // R8: the flag stays set until a write of 1
    p_eoc_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (eoc_q && !(wr_stat && bus_wdata[SB_EOC])) |=> eoc_q);

endmodule

// File: rtl/convseq_chdata.sv
module convseq_chdata
    import convseq_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int RES_W  = 10,
    parameter int CH_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             res_we,
    input  logic [CH_W-1:0]  res_ch,
    input  logic [RES_W-1:0] res_data,
    input  logic             rd_en,
    input  logic [CH_W-1:0]  rd_idx,
    output logic [BUS_W-1:0] rd_word
);

    localparam int PAD_W = BUS_W - 1 - RES_W;

    logic [NUM_CH-1:0][RES_W-1:0] dat_all;
    logic [NUM_CH-1:0]            new_all;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic [RES_W-1:0] dat_q;
        logic             new_q;
        logic             hit_wr, hit_rd;

        assign hit_wr = res_we && (res_ch == CH_W'(g));
        assign hit_rd = rd_en && (rd_idx == CH_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                dat_q <= '0;
                new_q <= 1'b0;
            end else if (hit_wr) begin
                dat_q <= res_data;
                new_q <= 1'b1;
            end else if (hit_rd) begin
                new_q <= 1'b0;
            end
        end

        assign dat_all[g] = dat_q;
        assign new_all[g] = new_q;
    end

    assign rd_word = {new_all[rd_idx], {PAD_W{1'b0}}, dat_all[rd_idx]};

    // R10: a stored result always comes with a raised fresh flag
    p_new_on_result_r10: assert property (@(posedge clk) disable iff (rst)
        res_we |=> new_all[$past(res_ch)]);

    // R10: a read without a simultaneous result clears the flag
    p_new_read_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !(res_we && res_ch == rd_idx)) |=> !new_all[$past(rd_idx)]);

endmodule

// File: rtl/convseq_fsm.sv
module convseq_fsm
    import convseq_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int RES_W  = 10,
    parameter int CH_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_flags_t       flags,
    input  logic [CH_W-1:0]   ch_addr,
    input  logic [NUM_CH-1:0] scan_map,
    input  logic              start_p,
    input  logic              stop_p,
    output logic              conv_req,
    output logic [CH_W-1:0]   conv_ch,
    input  logic              conv_ack,
    input  logic [RES_W-1:0]  conv_data,
    output logic              res_we,
    output logic [CH_W-1:0]   res_ch,
    output logic [RES_W-1:0]  res_data,
    output logic              eoc_set,
    output logic              busy
);

    seq_state_e      state_q, state_d;
    logic [CH_W-1:0] cur_q, cur_d;
    logic            first_found, next_found, halt;
    logic [CH_W-1:0] first_idx, next_idx;

    // lowest selected channel, and lowest selected channel above the current one
    always_comb begin
        first_found = 1'b0;
        first_idx   = '0;
        next_found  = 1'b0;
        next_idx    = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (scan_map[i]) begin
                first_found = 1'b1;
                first_idx   = CH_W'(i);
                if (i > int'(cur_q)) begin
                    next_found = 1'b1;
                    next_idx   = CH_W'(i);
                end
            end
        end
    end

    assign halt = stop_p || !flags.en;

    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        res_we  = 1'b0;
        eoc_set = 1'b0;
        case (state_q)
            SQ_IDLE: begin
                if (start_p) begin
                    if (!flags.scan_mode) begin
                        cur_d   = ch_addr;
                        state_d = SQ_REQ;
                    end else if (first_found) begin
                        cur_d   = first_idx;
                        state_d = SQ_REQ;
                    end
                end
            end
            SQ_REQ: begin
                if (conv_ack) begin
                    res_we = 1'b1;
                    if (!flags.scan_mode) begin
                        eoc_set = 1'b1;
                        state_d = flags.repeat_on ? SQ_GAP : SQ_IDLE;
                    end else if (next_found) begin
                        cur_d   = next_idx;
                        state_d = SQ_GAP;
                    end else begin
                        eoc_set = 1'b1;
                        if (flags.repeat_on && first_found) begin
                            cur_d   = first_idx;
                            state_d = SQ_GAP;
                        end else begin
                            state_d = SQ_IDLE;
                        end
                    end
                end
            end
            SQ_GAP:  state_d = SQ_REQ;
            default: state_d = SQ_IDLE;
        endcase
        if (halt) begin
            state_d = SQ_IDLE;
            res_we  = 1'b0;
            eoc_set = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            cur_q   <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
        end
    end

    assign conv_req = (state_q == SQ_REQ);
    assign conv_ch  = cur_q;
    assign res_ch   = cur_q;
    assign res_data = conv_data;
    assign busy     = (state_q != SQ_IDLE);

    // R12: channel held while the request waits
    p_ch_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (conv_req && !conv_ack) |=> (!conv_req || $stable(conv_ch)));

    // R12: request drops after an acknowledge
    p_req_drop_r12: assert property (@(posedge clk) disable iff (rst)
        (conv_req && conv_ack) |=> !conv_req);

    // R6: stop idles the sequencer
    p_stop_idle_r6: assert property (@(posedge clk) disable iff (rst)
        stop_p |=> !busy);

    // R7: no request while disabled
    p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !flags.en |=> !conv_req);

    // R2: a one-shot single conversion ends after its result
    p_oneshot_done_r2: assert property (@(posedge clk) disable iff (rst)
        (res_we && !flags.scan_mode && !flags.repeat_on) |=> !busy);

endmodule

// File: rtl/convseq_top.sv
module convseq_top
    import convseq_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int RES_W  = 10,
    parameter int DIV_W  = 6,
    parameter int ADDR_W = 5,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              conv_req,
    output logic [CH_W-1:0]   conv_ch,
    input  logic              conv_ack,
    input  logic [RES_W-1:0]  conv_data,
    output logic              conv_tick,
    output logic              irq
);

    ctrl_flags_t       flags;
    logic [CH_W-1:0]   ch_addr;
    logic [NUM_CH-1:0] scan_map;
    logic [DIV_W-1:0]  div_val;
    logic              start_p, stop_p, eoc_set, busy;
    logic              ch_rd_en;
    logic [CH_W-1:0]   ch_rd_idx;
    logic [BUS_W-1:0]  ch_rd_word;
    logic              res_we;
    logic [CH_W-1:0]   res_ch;
    logic [RES_W-1:0]  res_data;

    convseq_regs #(
        .NUM_CH(NUM_CH), .DIV_W(DIV_W), .ADDR_W(ADDR_W), .CH_W(CH_W)
    ) u_regs (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .flags(flags), .ch_addr(ch_addr), .scan_map(scan_map), .div_val(div_val),
        .start_p(start_p), .stop_p(stop_p), .eoc_set(eoc_set), .busy(busy),
        .irq(irq), .ch_rd_en(ch_rd_en), .ch_rd_idx(ch_rd_idx), .ch_rd_word(ch_rd_word)
    );

    convseq_fsm #(
        .NUM_CH(NUM_CH), .RES_W(RES_W), .CH_W(CH_W)
    ) u_fsm (
        .clk(clk), .rst(rst), .flags(flags), .ch_addr(ch_addr), .scan_map(scan_map),
        .start_p(start_p), .stop_p(stop_p),
        .conv_req(conv_req), .conv_ch(conv_ch), .conv_ack(conv_ack), .conv_data(conv_data),
        .res_we(res_we), .res_ch(res_ch), .res_data(res_data),
        .eoc_set(eoc_set), .busy(busy)
    );

    convseq_chdata #(
        .NUM_CH(NUM_CH), .RES_W(RES_W), .CH_W(CH_W)
    ) u_chdata (
        .clk(clk), .rst(rst), .res_we(res_we), .res_ch(res_ch), .res_data(res_data),
        .rd_en(ch_rd_en), .rd_idx(ch_rd_idx), .rd_word(ch_rd_word)
    );

    convseq_prescaler #(
        .DIV_W(DIV_W)
    ) u_presc (
        .clk(clk), .rst(rst), .en(flags.en), .div_val(div_val), .tick(conv_tick)
    );

endmodule

// File: tb/convseq_top_test.sv
module convseq_top_test;

    localparam int NUM_CH = 8;
    localparam int RES_W  = 10;
    localparam int ADDR_W = 5;
    localparam int CH_W   = 3;
    localparam int LAT    = 3;

    localparam int C_EN = 16'h0001, C_MODE = 16'h0002, C_RPT = 16'h0004, C_IEN = 16'h0008;
    localparam int C_START = 16'h0100, C_STOP = 16'h0200;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_sel = 1'b0, bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [15:0]       bus_wdata = '0;
    logic [15:0]       bus_rdata;
    logic              conv_req, conv_tick, irq;
    logic [CH_W-1:0]   conv_ch;
    logic              conv_ack = 1'b0;
    logic [RES_W-1:0]  conv_data = '0;

    int tests = 0, fails = 0;
    int log_ch[64];
    int log_dat[64];
    int log_n = 0;
    int hs_err = 0;
    int wait_cnt = 0;
    int held_ch = 0;
    int irq_at = -1;
    bit resp_on = 1'b1;
    bit done = 1'b0;

    always #4 clk = ~clk;

    convseq_top uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_req(conv_req), .conv_ch(conv_ch),
        .conv_ack(conv_ack), .conv_data(conv_data), .conv_tick(conv_tick), .irq(irq)
    );

    function automatic int pat(int n, int ch);
        return (ch * 71 + n * 13 + 5) % 1024;
    endfunction

    // fixed-latency converter model, also watching the handshake (R12)
    initial begin
        forever begin
            @(negedge clk);
            if (conv_ack) begin
                if (conv_req) hs_err++;
                conv_ack = 1'b0;
                wait_cnt = 0;
            end else if (conv_req && resp_on) begin
                if (wait_cnt > 0 && int'(conv_ch) != held_ch) hs_err++;
                held_ch = int'(conv_ch);
                if (wait_cnt == LAT) begin
                    conv_data = RES_W'(pat(log_n, held_ch));
                    conv_ack  = 1'b1;
                    if (log_n < 64) begin
                        log_ch[log_n]  = held_ch;
                        log_dat[log_n] = pat(log_n, held_ch);
                    end
                    log_n++;
                    wait_cnt = 0;
                end else begin
                    wait_cnt++;
                end
            end else begin
                wait_cnt = 0;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (irq && irq_at < 0) irq_at = log_n;
        end
    end

    task automatic check(string rq, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic bus_write(int a, int d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1;
        bus_addr = ADDR_W'(a); bus_wdata = 16'(d);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(int a, output int v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ADDR_W'(a);
        @(negedge clk);
        v = int'(bus_rdata);
        bus_sel = 1'b0;
    endtask

    task automatic wait_idle();
        int v;
        repeat (3) @(negedge clk);
        for (int k = 0; k < 500; k++) begin
            bus_read(1, v);
            if ((v & 2) == 0) break;
        end
    endtask

    task automatic wait_logs(int n);
        for (int k = 0; k < 3000 && log_n < n; k++) @(negedge clk);
    endtask

    task automatic count_ticks(int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            if (conv_tick) c++;
        end
    endtask

    task automatic t_reset();
        int v;
        check("R1", "conv_req after reset", int'(conv_req), 0);
        check("R1", "irq after reset", int'(irq), 0);
        bus_read(0, v); check("R1", "control reads 0", v, 0);
        bus_read(1, v); check("R1", "status reads 0", v, 0);
        bus_read(2, v); check("R1", "bitmap reads 0", v, 0);
        bus_read(3, v); check("R1", "divider reads 0", v, 0);
        bus_read(16 + 3, v); check("R1", "channel 3 reads 0", v, 0);
    endtask

    task automatic t_enable_gate();
        int v, base;
        base = log_n;
        bus_write(0, C_START | (2 << 4));
        repeat (10) @(negedge clk);
        check("R7", "no request when disabled", int'(conv_req), 0);
        check("R7", "no conversion when disabled", log_n - base, 0);
        bus_read(1, v); check("R7", "busy stays 0", (v >> 1) & 1, 0);
    endtask

    task automatic t_single_oneshot();
        int v, base;
        base = log_n;
        bus_write(0, C_EN | (6 << 4) | C_START);
        wait_idle();
        check("R2", "one conversion", log_n - base, 1);
        check("R2", "addressed channel", log_ch[base], 6);
        bus_read(1, v); check("R2", "back to idle", (v >> 1) & 1, 0);
        check("R8", "eoc set after single", v & 1, 1);
        bus_read(16 + 6, v); check("R10", "fresh result word", v, 32768 + log_dat[base]);
        bus_read(16 + 6, v); check("R10", "flag cleared, data kept", v, log_dat[base]);
        check("R9", "irq low without enable", int'(irq), 0);
        bus_write(0, C_EN | C_IEN | (6 << 4));
        check("R9", "irq high with enable", int'(irq), 1);
        bus_write(1, 0);
        bus_read(1, v); check("R8", "write 0 keeps eoc", v & 1, 1);
        bus_write(1, 1);
        bus_read(1, v); check("R8", "write 1 clears eoc", v & 1, 0);
        check("R9", "irq low after clear", int'(irq), 0);
    endtask

    task automatic t_single_repeat();
        int v, base, after, bad;
        base = log_n;
        bus_write(0, C_EN | C_RPT | (5 << 4) | C_START);
        wait_logs(base + 4);
        bus_write(0, C_EN | C_STOP);
        repeat (2) @(negedge clk);
        after = log_n;
        check("R3", "repeated conversions", (after - base >= 4) ? 1 : 0, 1);
        bad = 0;
        for (int i = base; i < after && i < 64; i++) if (log_ch[i] != 5) bad++;
        check("R3", "all on channel 5", bad, 0);
        repeat (20) @(negedge clk);
        check("R6", "no conversion after stop", log_n - after, 0);
        bus_read(1, v); check("R6", "idle after stop", (v >> 1) & 1, 0);
    endtask

    task automatic t_stop_and_disable();
        int v, base;
        resp_on = 1'b0;
        bus_write(0, C_EN | (1 << 4) | C_START);
        repeat (5) @(negedge clk);
        check("R12", "request held while waiting", int'(conv_req), 1);
        check("R12", "requested channel", int'(conv_ch), 1);
        bus_write(0, C_EN | C_STOP);
        @(negedge clk);
        check("R6", "request dropped by stop", int'(conv_req), 0);
        base = log_n;
        resp_on = 1'b1;
        repeat (10) @(negedge clk);
        check("R6", "nothing converted after stop", log_n - base, 0);
        base = log_n;
        bus_write(0, C_EN | C_RPT | (2 << 4) | C_START);
        wait_logs(base + 2);
        bus_write(0, 0);
        @(negedge clk);
        check("R7", "request dropped by disable", int'(conv_req), 0);
        bus_read(1, v); check("R7", "idle after disable", (v >> 1) & 1, 0);
    endtask

    task automatic t_scan_oneshot();
        int v, base, bad;
        int exp_ch[4] = '{0, 2, 3, 5};
        bus_write(1, 1);
        bus_write(2, 8'h2D);
        irq_at = -1;
        base = log_n;
        bus_write(0, C_EN | C_MODE | C_IEN | C_START);
        wait_idle();
        check("R4", "four conversions", log_n - base, 4);
        bad = 0;
        for (int i = 0; i < 4; i++) if (log_ch[base + i] != exp_ch[i]) bad++;
        check("R4", "ascending order", bad, 0);
        check("R8", "eoc only after last channel", irq_at, base + 4);
        for (int i = 0; i < 4; i++) begin
            bus_read(16 + exp_ch[i], v);
            check("R10", "scan result word", v, 32768 + log_dat[base + i]);
        end
        bus_write(1, 1);
        bus_write(2, 0);
        base = log_n;
        bus_write(0, C_EN | C_MODE | C_START);
        repeat (10) @(negedge clk);
        check("R4", "empty bitmap ignored", log_n - base, 0);
        check("R4", "no request on empty bitmap", int'(conv_req), 0);
    endtask

    task automatic t_scan_repeat();
        int base, bad;
        int exp_ch[7] = '{1, 4, 7, 1, 4, 7, 1};
        bus_write(2, 8'h92);
        base = log_n;
        bus_write(0, C_EN | C_MODE | C_RPT | C_START);
        wait_logs(base + 7);
        bus_write(0, C_EN | C_STOP);
        bad = 0;
        for (int i = 0; i < 7; i++) if (log_ch[base + i] != exp_ch[i]) bad++;
        check("R5", "sweep wraps to lowest", bad, 0);
    endtask

    task automatic t_prescaler();
        int c, v;
        bus_write(0, C_EN);
        bus_write(3, 3);
        repeat (70) @(negedge clk);
        count_ticks(40, c); check("R11", "divide by 4", c, 10);
        bus_write(3, 16'hFFFF);
        bus_read(3, v); check("R11", "divider clipped to 6 bits", v, 63);
        repeat (70) @(negedge clk);
        count_ticks(128, c); check("R11", "divide by 64", c, 2);
        bus_write(3, 0);
        repeat (70) @(negedge clk);
        count_ticks(20, c); check("R11", "divide by 1", c, 20);
        bus_write(0, 0);
        count_ticks(20, c); check("R11", "no tick when disabled", c, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_enable_gate();
        t_single_oneshot();
        t_single_repeat();
        t_stop_and_disable();
        t_scan_oneshot();
        t_scan_repeat();
        t_prescaler();
        check("R12", "handshake violations", hs_err, 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R12 watchdog: actual hung expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule